// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves an 18-bit word between two ports, A and B, in both directions at once. Each direction has its own storage element and three controls: an output enable, a latch enable and a capture strobe. With the latch enable high, the receiving port follows the sending port with no clock delay. With the latch enable low, the stored word is held, and a rising strobe loads a new word. The A-to-B output enable is active high. The B-to-A output enable is active low.

Everything runs on one fast system clock. The latch enables and strobes are sampled on its rising edge. Strobe edges are found by comparing two samples, so no real latch is built. The ports are not inout pins. Each port has a data input, a per-bit drive-valid input, a data output and a per-bit output-enable vector. A per-bit keeper remembers the last actively driven value of each input bus. That value is used while the bus is undriven, in place of pull resistors.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While `ab_le_i` is 1, `b_o` equals the effective A input in the same cycle, with no clock delay. After each system clock edge, the A-to-B storage holds that value.
- R2: While `ab_le_i` is 0 and no rising strobe is seen, `b_o` keeps the stored word whatever `a_i` does.
- R3: While `ab_le_i` is 0, a rising strobe loads the effective A input into storage. A rising strobe is a system-clock sample of 1 on `ab_stb_i` after a sample of 0. The new word appears on `b_o` right after that clock edge.
- R4: When `ab_le_i` falls while `ab_stb_i` is held at 1, `b_o` keeps the value it had just before the fall.
- R5: The A-to-B enable `ab_oe_i` is active high. All 18 bits of `b_oe_o` are 1 when it is 1 and 0 when it is 0, whatever the latch enable and strobe are doing.
- R6: The B-to-A enable `ba_oe_ni` is active low, so `a_oe_o` is all ones only when it is 0. The B-to-A path provides transparent, hold and capture behaviour from `b_i` to `a_o`, using `ba_le_i` and `ba_stb_i`.
- R7: The two directions have separate storage. Activity on one direction's controls does not change the word stored in the other direction.
- R8: Each input bit has a keeper. While that bit's drive-valid input (`a_drv_i`/`b_drv_i`) is 1, the effective input is the external bit and the keeper takes its value. While the drive-valid bit is 0, the effective input is the keeper value.
- R9: `rst_ni` low clears both storage words and both keepers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 18 | Data seen on port A |
| a_drv_i | input | 18 | Per-bit: port A bit driven externally |
| b_i | input | 18 | Data seen on port B |
| b_drv_i | input | 18 | Per-bit: port B bit driven externally |
| ab_oe_i | input | 1 | A-to-B output enable, active high |
| ab_le_i | input | 1 | A-to-B latch enable |
| ab_stb_i | input | 1 | A-to-B capture strobe |
| ba_oe_ni | input | 1 | B-to-A output enable, active low |
| ba_le_i | input | 1 | B-to-A latch enable |
| ba_stb_i | input | 1 | B-to-A capture strobe |
| a_o | output | 18 | Data driven onto port A |
| a_oe_o | output | 18 | Per-bit drive enable for port A |
| b_o | output | 18 | Data driven onto port B |
| b_oe_o | output | 18 | Per-bit drive enable for port B |

## Verification
The bench drops the latch enable while the strobe is still high. A design that treated the held-high strobe as a new edge would load the current A word there instead of keeping the last transparent value. The bench raises the strobe once and then changes `a_i` while the strobe stays high. A level-sensitive capture would follow that change. It swaps the enable polarities and drives transparent mode with both enables off, which would expose a shared or inverted enable. Partial drive-valid masks and fully undriven buses check that the keeper holds per bit, and that a capture taken while the bus is undriven loads the kept word rather than the floating input.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int XCVR_W = 18;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'd0,
    MODE_FLOW = 2'd1,
    MODE_EDGE = 2'd2
  } xfer_mode_e;
endpackage

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] bus_i,
  input  logic [W-1:0] drv_i,
  output logic [W-1:0] eff_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic held_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       held_q <= 1'b0;
      else if (drv_i[i]) held_q <= bus_i[i];
    end
    assign eff_o[i] = drv_i[i] ? bus_i[i] : held_q;
  end
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int W         = 18,
  parameter bit OE_ACTLOW = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic         le_i,
  input  logic         stb_i,
  input  logic         oe_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] oe_o
);
  logic         stb_q;
  logic         stb_rise;
  logic [W-1:0] store_q;
  xfer_mode_e   mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_q <= 1'b0;
    else         stb_q <= stb_i;
  end

  assign stb_rise = stb_i & ~stb_q;

  always_comb begin
    if (le_i)          mode = MODE_FLOW;
    else if (stb_rise) mode = MODE_EDGE;
    else               mode = MODE_HOLD;
  end

  // flow mode reloads every clock so the word is already held when le drops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) store_q <= '0;
    else if (mode != MODE_HOLD) store_q <= d_i;
  end

  assign q_o = (mode == MODE_FLOW) ? d_i : store_q;

  logic en;
  if (OE_ACTLOW) begin : g_oe_low
    assign en = ~oe_i;
  end else begin : g_oe_high
    assign en = oe_i;
  end
  assign oe_o = {W{en}};
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import xcvr_pkg::*;
#(
  parameter int W = XCVR_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] a_drv_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] b_drv_i,
  input  logic         ab_oe_i,
  input  logic         ab_le_i,
  input  logic         ab_stb_i,
  input  logic         ba_oe_ni,
  input  logic         ba_le_i,
  input  logic         ba_stb_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] a_oe_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] b_oe_o
);
  logic [W-1:0] a_eff, b_eff;

  xcvr_keeper #(.W(W)) u_keep_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_i(a_i), .drv_i(a_drv_i), .eff_o(a_eff)
  );
  xcvr_keeper #(.W(W)) u_keep_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_i(b_i), .drv_i(b_drv_i), .eff_o(b_eff)
  );

  xcvr_path #(.W(W), .OE_ACTLOW(1'b0)) u_ab (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(a_eff), .le_i(ab_le_i),
    .stb_i(ab_stb_i), .oe_i(ab_oe_i), .q_o(b_o), .oe_o(b_oe_o)
  );
  xcvr_path #(.W(W), .OE_ACTLOW(1'b1)) u_ba (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(b_eff), .le_i(ba_le_i),
    .stb_i(ba_stb_i), .oe_i(ba_oe_ni), .q_o(a_o), .oe_o(a_oe_o)
  );
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int W = 18
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] a_i,
  input logic [W-1:0] a_drv_i,
  input logic [W-1:0] b_drv_i,
  input logic         ab_oe_i,
  input logic         ab_le_i,
  input logic         ab_stb_i,
  input logic         ba_oe_ni,
  input logic         ba_le_i,
  input logic [W-1:0] a_o,
  input logic [W-1:0] a_oe_o,
  input logic [W-1:0] b_o,
  input logic [W-1:0] b_oe_o
);
  logic [1:0] age_q;
  logic       ready;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= 2'd0;
    else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
  end
  assign ready = (age_q == 2'd2);

  // R1
  ab_flow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ab_le_i && (&a_drv_i)) |-> (b_o == a_i));

  // R2
  ab_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && !ab_le_i && $past(!ab_le_i) && !($past(ab_stb_i) && !$past(ab_stb_i, 2)))
    |-> (b_o == $past(b_o)));

  // R3
  ab_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && !ab_le_i && ab_stb_i && !$past(ab_stb_i) && (&a_drv_i))
    |=> (ab_le_i || b_o == $past(a_i)));

  // R5
  ab_oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ab_oe_i |-> (b_oe_o == '0));

  // R5
  ab_oe_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ab_oe_i |-> (&b_oe_o));

  // R6
  ba_oe_pol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ba_oe_ni |-> (a_oe_o == '0));

  // R8
  b_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && ba_le_i && $past(ba_le_i) && (b_drv_i == '0) && ($past(b_drv_i) == '0))
    |-> $stable(a_o));
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .a_drv_i(a_drv_i), .b_drv_i(b_drv_i),
  .ab_oe_i(ab_oe_i), .ab_le_i(ab_le_i), .ab_stb_i(ab_stb_i), .ba_oe_ni(ba_oe_ni),
  .ba_le_i(ba_le_i), .a_o(a_o), .a_oe_o(a_oe_o), .b_o(b_o), .b_oe_o(b_oe_o)
);

// File: tb/tb_bus_xcvr_reg.sv
module tb_bus_xcvr_reg;
  localparam int W = 18;
  localparam time CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {le, stb, a, expected b}
  localparam logic [37:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 18'h12345, 18'h12345},  // R1
    {1'b1, 1'b0, 18'h00abc, 18'h00abc},  // R1
    {1'b0, 1'b0, 18'h3ffff, 18'h00abc},  // R2
    {1'b0, 1'b1, 18'h15555, 18'h15555},  // R3
    {1'b0, 1'b1, 18'h2aaaa, 18'h15555},  // R2 strobe held high
    {1'b0, 1'b0, 18'h3ffff, 18'h15555},  // R2
    {1'b1, 1'b1, 18'h0f0f0, 18'h0f0f0},  // R1 with strobe high
    {1'b0, 1'b1, 18'h30303, 18'h0f0f0},  // R4
    {1'b0, 1'b0, 18'h00000, 18'h0f0f0},  // R2
    {1'b0, 1'b1, 18'h3c3c3, 18'h3c3c3}   // R3
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] a_i = '0, a_drv_i = '1, b_i = '0, b_drv_i = '1;
  logic ab_oe_i = 1'b1, ab_le_i = 1'b0, ab_stb_i = 1'b0;
  logic ba_oe_ni = 1'b1, ba_le_i = 1'b0, ba_stb_i = 1'b0;
  logic [W-1:0] a_o, a_oe_o, b_o, b_oe_o;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_xcvr_reg #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a_i), .a_drv_i(a_drv_i), .b_i(b_i),
    .b_drv_i(b_drv_i), .ab_oe_i(ab_oe_i), .ab_le_i(ab_le_i), .ab_stb_i(ab_stb_i),
    .ba_oe_ni(ba_oe_ni), .ba_le_i(ba_le_i), .ba_stb_i(ba_stb_i),
    .a_o(a_o), .a_oe_o(a_oe_o), .b_o(b_o), .b_oe_o(b_oe_o)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
    end
  endtask

  // inputs change on the falling edge; results sampled 1 time unit after the rising edge
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drive();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    drive(); rst_ni = 1'b1;
    step();
    check("R9 b after reset", b_o, '0);
    check("R9 a after reset", a_o, '0);

    for (int i = 0; i < NVEC; i++) begin
      drive();
      ab_le_i  = VEC[i][37];
      ab_stb_i = VEC[i][36];
      a_i      = VEC[i][35:18];
      step();
      check($sformatf("R1-4 vec%0d", i), b_o, VEC[i][17:0]);
    end

    // R5: enable level alone sets b_oe_o
    drive(); ab_oe_i = 1'b0; ab_le_i = 1'b1; a_i = 18'h2468a;
    step();
    check("R5 oe off", b_oe_o, '0);
    drive(); ab_oe_i = 1'b1;
    step();
    check("R5 oe on", b_oe_o, '1);

    // R6: active-low enable and B-to-A modes
    check("R6 oe high disables", a_oe_o, '0);
    drive(); ba_oe_ni = 1'b0; ba_le_i = 1'b1; b_i = 18'h2468a;
    step();
    check("R6 oe low enables", a_oe_o, '1);
    check("R6 transparent", a_o, 18'h2468a);
    drive(); ba_le_i = 1'b0; b_i = 18'h13579;
    step();
    check("R6 hold", a_o, 18'h2468a);
    drive(); ba_stb_i = 1'b1;
    step();
    check("R6 capture", a_o, 18'h13579);

    // R7: A-to-B activity leaves B-to-A storage alone
    drive(); ab_le_i = 1'b0; ab_stb_i = 1'b0; b_i = 18'h00001;
    step();
    drive(); ab_stb_i = 1'b1; a_i = 18'h0beef;
    step();
    check("R7 ab captured", b_o, 18'h0beef);
    check("R7 ba untouched", a_o, 18'h13579);

    // R8: keeper on port B
    drive(); ba_stb_i = 1'b0; ba_le_i = 1'b1; b_drv_i = '1; b_i = 18'h11111;
    step();
    drive(); b_drv_i = 18'h000ff; b_i = 18'h3ff00;
    step();
    check("R8 partial drive", a_o, 18'h11100);
    drive(); b_drv_i = '0; b_i = 18'h2222e;
    step();
    check("R8 undriven keeps", a_o, 18'h11100);
    drive(); ba_le_i = 1'b0;
    step();
    drive(); ba_stb_i = 1'b1; b_i = 18'h3ffff;
    step();
    check("R8 capture from keeper", a_o, 18'h11100);

    // R8 on port A, then R9 clears keepers
    drive(); ab_le_i = 1'b1; a_drv_i = '1; a_i = 18'h0aaaa;
    step();
    drive(); a_drv_i = '0; a_i = 18'h35555;
    step();
    check("R8 a keeper", b_o, 18'h0aaaa);
    drive(); rst_ni = 1'b0; ab_stb_i = 1'b0; ba_stb_i = 1'b0;
    step();
    drive(); rst_ni = 1'b1;
    step();
    check("R9 a keeper cleared", b_o, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule